// File: doc/BRIEF.md
# Programmable Flash Bus-Cycle Sequencer

This block runs one external bus transfer at a time for a NAND flash controller. A transfer is a read, a write, or a latch update. Each transfer first requests the shared external bus and waits for the grant. It then drives the address, and the data for writes and latch updates, for one setup cycle. Next come a strobe phase of n clocks and a hold phase of m clocks, where n and m come from a timing register. A final hold cycle follows. After that the sequencer goes back to idle, or starts the next transfer at once if one is waiting. The read and write strobes end at different points. The data bus is released one cycle after the address bus.

A small register port sets the timing and holds a latch-state word. The same port carries two commands. One returns every register to its default. The other requests a latch-update transfer, which drives the stored latch state onto the data bus under the address-latch strobe. Host logic starts reads and writes with a start pulse. It sees the end of each transfer through a one-cycle done pulse. Read data is held on a separate output.

Top module: `nand_bus_seq`

## Requirements
- R1: The sequence is idle, bus-get, setup, n strobe cycles, m hold cycles, final hold. `bus_req_o` is high from bus-get through final hold. The block stays in bus-get, with address and strobes inactive, until `bus_ack_i` is high at a clock edge.
- R2: Timing register (address 0): bits [3:0] give n and bits [7:4] give m, each 1 to 15. A field value of 0 acts as 1.
- R3: In a write transfer, `wr_n_o` is low for exactly the n strobe cycles and high at all other times. It never goes low in reads or latch updates.
- R4: In a read transfer, `rd_n_o` is low for n+1 cycles: the strobe cycles plus the first hold cycle. `data_i` is captured at the edge that ends the last strobe cycle and stays on `rdata_o` until the next read captures.
- R5: From setup through final hold, `addr_oe_o` is high and `addr_o` carries the transfer address. For reads and writes, the chip select chosen by `cs_sel_i` is low over the same span. Setup comes one cycle before any strobe.
- R6: In final hold, all strobes are inactive and the address is still driven. `addr_oe_o` drops after final hold. For writes and latch updates, `data_oe_o` stays high one cycle longer with the same `data_o`.
- R7: `done_o` is high for one cycle, in the cycle after final hold.
- R8: `start_i` (with `rw_i` = 1 for read, `addr_i`, `wdata_i`, `cs_sel_i`) is taken only in idle or in final hold. Taken in final hold, the next transfer goes straight to bus-get with no idle cycle. At any other time it is ignored.
- R9: Strobe and hold counts are captured when a transfer is taken. A timing write during a transfer affects only later transfers.
- R10: A write of any value to address 1 sets the timing fields to their defaults (n=6, m=2), clears the latch state and cancels a pending latch update. A transfer already running finishes unchanged.
- R11: A write to address 3 stores the latch state from bits [3:0] and starts no transfer. A write of any value to address 2 requests a latch update. That transfer drives the latch state, zero-extended, on `data_o` with the address at 0. `ale_o` is high through the strobe and hold cycles. No chip select, read strobe or write strobe is active. A pending latch update wins over `start_i` at the same decision point, and that start is dropped.
- R12: After reset, `bus_req_o`, `addr_oe_o`, `data_oe_o`, `ale_o` and `done_o` are low. `rd_n_o`, `wr_n_o` and all `cs_n_o` bits are high, and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transfer request pulse |
| rw_i | input | 1 | 1 = read, 0 = write |
| cs_sel_i | input | CSW | Chip select index |
| addr_i | input | AW | Transfer address |
| wdata_i | input | DW | Write data |
| reg_we_i | input | 1 | Register port write strobe |
| reg_addr_i | input | 2 | Register port address |
| reg_wdata_i | input | 2*CNT_W | Register port write data |
| bus_ack_i | input | 1 | External bus grant |
| data_i | input | DW | External data bus, read side |
| bus_req_o | output | 1 | External bus request |
| cs_n_o | output | NCS | Active-low chip selects |
| addr_o | output | AW | External address |
| addr_oe_o | output | 1 | Address drive enable |
| data_o | output | DW | External data bus, write side |
| data_oe_o | output | 1 | Data drive enable |
| ale_o | output | 1 | Address-latch strobe |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rdata_o | output | DW | Captured read data |

## Verification
The hardest case to reach from the ports is a pending latch update meeting a held start request at the final hold of a running write. At that single cycle the priority rule, the chaining rule and the delayed data release all act together. The stimulus gets there by holding `start_i` high so that transfers chain. It then posts a latch-update command while a write is in its strobe phase. A separate run posts the command and then a register reset before the write ends, to show the request is cancelled. Read capture timing is exposed by changing `data_i` on every clock, so only the value present at the correct edge can match.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_BGET  = 3'd1,
      ST_SETUP = 3'd2,
      ST_PULSE = 3'd3,
      ST_HOLD  = 3'd4,
      ST_FHOLD = 3'd5
   } seq_state_e;

   typedef enum logic [1:0] {
      OP_RD  = 2'd0,
      OP_WR  = 2'd1,
      OP_LAT = 2'd2
   } seq_op_e;

   localparam logic [1:0] RA_TIMING = 2'd0;
   localparam logic [1:0] RA_SRESET = 2'd1;
   localparam logic [1:0] RA_LUPD   = 2'd2;
   localparam logic [1:0] RA_LSTATE = 2'd3;

endpackage

// File: rtl/nbs_regs.sv
module nbs_regs
   import nbs_pkg::*;
#(
   parameter int CNT_W    = 4,
   parameter int LAT_W    = 4,
   parameter int DEF_PW   = 6,
   parameter int DEF_HOLD = 2,
   localparam int REG_W   = 2 * CNT_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             reg_we_i,
   input  logic [1:0]       reg_addr_i,
   input  logic [REG_W-1:0] reg_wdata_i,
   input  logic             lat_taken_i,
   output logic [CNT_W-1:0] pw_o,
   output logic [CNT_W-1:0] hold_o,
   output logic [LAT_W-1:0] lat_o,
   output logic             pend_o
);

   localparam logic [CNT_W-1:0] PW_RST   = CNT_W'(DEF_PW);
   localparam logic [CNT_W-1:0] HOLD_RST = CNT_W'(DEF_HOLD);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pw_o   <= PW_RST;
         hold_o <= HOLD_RST;
         lat_o  <= '0;
         pend_o <= 1'b0;
      end else begin
         if (lat_taken_i) pend_o <= 1'b0;
         if (reg_we_i) begin
            unique case (reg_addr_i)
               RA_TIMING: begin
                  pw_o   <= reg_wdata_i[CNT_W-1:0];
                  hold_o <= reg_wdata_i[REG_W-1:CNT_W];
               end
               RA_SRESET: begin
                  pw_o   <= PW_RST;
                  hold_o <= HOLD_RST;
                  lat_o  <= '0;
                  pend_o <= 1'b0;
               end
               RA_LUPD:   pend_o <= 1'b1;
               RA_LSTATE: lat_o  <= reg_wdata_i[LAT_W-1:0];
               default:   ;
            endcase
         end
      end
   end

   // R10
   sreset_defaults_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && reg_addr_i == RA_SRESET) |=> (pw_o == PW_RST && hold_o == HOLD_RST && !pend_o && lat_o == '0));

   // R11
   lupd_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && reg_addr_i == RA_LUPD) |=> pend_o);

endmodule

// File: rtl/nbs_fsm.sv
module nbs_fsm
   import nbs_pkg::*;
#(
   parameter int AW    = 16,
   parameter int DW    = 8,
   parameter int CNT_W = 4,
   parameter int LAT_W = 4,
   parameter int CSW   = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             rw_i,
   input  logic [CSW-1:0]   cs_sel_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [DW-1:0]    wdata_i,
   input  logic             bus_ack_i,
   input  logic [CNT_W-1:0] pw_i,
   input  logic [CNT_W-1:0] hold_i,
   input  logic [LAT_W-1:0] lat_i,
   input  logic             pend_i,
   output seq_state_e       state_o,
   output logic [CNT_W-1:0] cnt_o,
   output seq_op_e          op_o,
   output logic [AW-1:0]    addr_o,
   output logic [DW-1:0]    pay_o,
   output logic [CSW-1:0]   cs_o,
   output logic             last_pulse_o,
   output logic             lat_taken_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   seq_state_e       state_d;
   logic [CNT_W-1:0] cnt_d;
   logic [CNT_W-1:0] pw_cur_q, hold_cur_q;
   logic             at_decision, take;
   logic             last_hold;

   assign at_decision  = (state_o == ST_IDLE) || (state_o == ST_FHOLD);
   assign take         = at_decision && (pend_i || start_i);
   assign lat_taken_o  = take && pend_i;
   assign last_pulse_o = (state_o == ST_PULSE) && (cnt_o == pw_cur_q);
   assign last_hold    = (state_o == ST_HOLD) && (cnt_o == hold_cur_q);

   always_comb begin
      state_d = state_o;
      cnt_d   = '0;
      unique case (state_o)
         ST_IDLE:  if (take) state_d = ST_BGET;
         ST_BGET:  if (bus_ack_i) state_d = ST_SETUP;
         ST_SETUP: begin
            state_d = ST_PULSE;
            cnt_d   = ONE;
         end
         ST_PULSE: begin
            if (last_pulse_o) begin
               state_d = ST_HOLD;
               cnt_d   = ONE;
            end else begin
               cnt_d = cnt_o + ONE;
            end
         end
         ST_HOLD: begin
            if (last_hold) state_d = ST_FHOLD;
            else           cnt_d   = cnt_o + ONE;
         end
         ST_FHOLD: state_d = take ? ST_BGET : ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_o    <= ST_IDLE;
         cnt_o      <= '0;
         op_o       <= OP_RD;
         addr_o     <= '0;
         pay_o      <= '0;
         cs_o       <= '0;
         pw_cur_q   <= ONE;
         hold_cur_q <= ONE;
      end else begin
         state_o <= state_d;
         cnt_o   <= cnt_d;
         if (take) begin
            pw_cur_q   <= (pw_i == '0) ? ONE : pw_i;
            hold_cur_q <= (hold_i == '0) ? ONE : hold_i;
            if (pend_i) begin
               op_o   <= OP_LAT;
               addr_o <= '0;
               pay_o  <= DW'(lat_i);
               cs_o   <= '0;
            end else begin
               op_o   <= rw_i ? OP_RD : OP_WR;
               addr_o <= addr_i;
               pay_o  <= wdata_i;
               cs_o   <= cs_sel_i;
            end
         end
      end
   end

   // R1
   bget_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_o == ST_BGET && !bus_ack_i) |=> state_o == ST_BGET);

   // R2
   pulse_count_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_o == ST_PULSE) |-> (cnt_o >= ONE && cnt_o <= pw_cur_q));

   // R8
   chain_no_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_o == ST_FHOLD && start_i) |=> state_o == ST_BGET);

   // R9
   count_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_o != ST_IDLE && state_o != ST_FHOLD) |=> $stable(pw_cur_q) && $stable(hold_cur_q));

endmodule

// File: rtl/nbs_pins.sv
module nbs_pins
   import nbs_pkg::*;
#(
   parameter int AW    = 16,
   parameter int DW    = 8,
   parameter int CNT_W = 4,
   parameter int NCS   = 2,
   parameter int CSW   = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  seq_state_e       state_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  seq_op_e          op_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [DW-1:0]    pay_i,
   input  logic [CSW-1:0]   cs_i,
   input  logic             last_pulse_i,
   input  logic             bus_ack_i,
   input  logic [DW-1:0]    data_i,
   output logic             bus_req_o,
   output logic [NCS-1:0]   cs_n_o,
   output logic [AW-1:0]    addr_o,
   output logic             addr_oe_o,
   output logic [DW-1:0]    data_o,
   output logic             data_oe_o,
   output logic             ale_o,
   output logic             rd_n_o,
   output logic             wr_n_o,
   output logic             done_o,
   output logic [DW-1:0]    rdata_o
);

   logic on_bus, strobing, drives_data;
   logic extra_q;
   logic [DW-1:0] dbus_q;

   assign on_bus      = (state_i == ST_SETUP) || (state_i == ST_PULSE) ||
                        (state_i == ST_HOLD)  || (state_i == ST_FHOLD);
   assign strobing    = (state_i == ST_PULSE) || (state_i == ST_HOLD);
   assign drives_data = (op_i != OP_RD);

   assign bus_req_o = (state_i != ST_IDLE);
   assign addr_oe_o = on_bus;
   assign addr_o    = addr_i;
   assign data_o    = dbus_q;
   assign data_oe_o = (on_bus && drives_data) || extra_q;
   assign wr_n_o    = !((state_i == ST_PULSE) && (op_i == OP_WR));
   assign rd_n_o    = !((op_i == OP_RD) &&
                        ((state_i == ST_PULSE) || ((state_i == ST_HOLD) && (cnt_i == CNT_W'(1)))));
   assign ale_o     = strobing && (op_i == OP_LAT);

   for (genvar g = 0; g < NCS; g++) begin : g_cs
      assign cs_n_o[g] = !(on_bus && (op_i != OP_LAT) && (cs_i == CSW'(g)));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dbus_q  <= '0;
         extra_q <= 1'b0;
         done_o  <= 1'b0;
         rdata_o <= '0;
      end else begin
         if (state_i == ST_BGET && bus_ack_i) dbus_q <= pay_i;
         extra_q <= (state_i == ST_FHOLD) && drives_data;
         done_o  <= (state_i == ST_FHOLD);
         if (last_pulse_i && op_i == OP_RD) rdata_o <= data_i;
      end
   end

   // R3
   wr_ends_into_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(wr_n_o) |-> state_i == ST_HOLD);

   // R4
   rd_covers_first_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (last_pulse_i && op_i == OP_RD) |=> !rd_n_o);

   // R5
   setup_before_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(addr_oe_o) |-> (rd_n_o && wr_n_o && !ale_o && $past(bus_req_o)));

   // R6
   data_after_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(addr_oe_o) && $past(data_oe_o)) |-> (data_oe_o && $stable(data_o)));

   // R7
   done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
   import nbs_pkg::*;
#(
   parameter int AW       = 16,
   parameter int DW       = 8,
   parameter int CNT_W    = 4,
   parameter int NCS      = 2,
   parameter int LAT_W    = 4,
   parameter int DEF_PW   = 6,
   parameter int DEF_HOLD = 2,
   localparam int CSW     = $clog2(NCS),
   localparam int REG_W   = 2 * CNT_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             rw_i,
   input  logic [CSW-1:0]   cs_sel_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [DW-1:0]    wdata_i,
   input  logic             reg_we_i,
   input  logic [1:0]       reg_addr_i,
   input  logic [REG_W-1:0] reg_wdata_i,
   input  logic             bus_ack_i,
   input  logic [DW-1:0]    data_i,
   output logic             bus_req_o,
   output logic [NCS-1:0]   cs_n_o,
   output logic [AW-1:0]    addr_o,
   output logic             addr_oe_o,
   output logic [DW-1:0]    data_o,
   output logic             data_oe_o,
   output logic             ale_o,
   output logic             rd_n_o,
   output logic             wr_n_o,
   output logic             done_o,
   output logic [DW-1:0]    rdata_o
);

   if (NCS < 2) begin : g_bad_ncs
      $error("nand_bus_seq: NCS must be at least 2");
   end
   if (LAT_W > DW || LAT_W > REG_W) begin : g_bad_lat
      $error("nand_bus_seq: LAT_W exceeds data or register width");
   end
   if (DEF_PW < 1 || DEF_PW >= (1 << CNT_W) || DEF_HOLD < 1 || DEF_HOLD >= (1 << CNT_W)) begin : g_bad_def
      $error("nand_bus_seq: default counts out of range");
   end

   logic [CNT_W-1:0] pw_w, hold_w, cnt_w;
   logic [LAT_W-1:0] lat_w;
   logic             pend_w, lat_taken_w, last_pulse_w;
   seq_state_e       state_w;
   seq_op_e          op_w;
   logic [AW-1:0]    cur_addr_w;
   logic [DW-1:0]    pay_w;
   logic [CSW-1:0]   cs_w;

   nbs_regs #(
      .CNT_W(CNT_W), .LAT_W(LAT_W), .DEF_PW(DEF_PW), .DEF_HOLD(DEF_HOLD)
   ) regs_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .reg_we_i    (reg_we_i),
      .reg_addr_i  (reg_addr_i),
      .reg_wdata_i (reg_wdata_i),
      .lat_taken_i (lat_taken_w),
      .pw_o        (pw_w),
      .hold_o      (hold_w),
      .lat_o       (lat_w),
      .pend_o      (pend_w)
   );

   nbs_fsm #(
      .AW(AW), .DW(DW), .CNT_W(CNT_W), .LAT_W(LAT_W), .CSW(CSW)
   ) fsm_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .start_i      (start_i),
      .rw_i         (rw_i),
      .cs_sel_i     (cs_sel_i),
      .addr_i       (addr_i),
      .wdata_i      (wdata_i),
      .bus_ack_i    (bus_ack_i),
      .pw_i         (pw_w),
      .hold_i       (hold_w),
      .lat_i        (lat_w),
      .pend_i       (pend_w),
      .state_o      (state_w),
      .cnt_o        (cnt_w),
      .op_o         (op_w),
      .addr_o       (cur_addr_w),
      .pay_o        (pay_w),
      .cs_o         (cs_w),
      .last_pulse_o (last_pulse_w),
      .lat_taken_o  (lat_taken_w)
   );

   nbs_pins #(
      .AW(AW), .DW(DW), .CNT_W(CNT_W), .NCS(NCS), .CSW(CSW)
   ) pins_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .state_i      (state_w),
      .cnt_i        (cnt_w),
      .op_i         (op_w),
      .addr_i       (cur_addr_w),
      .pay_i        (pay_w),
      .cs_i         (cs_w),
      .last_pulse_i (last_pulse_w),
      .bus_ack_i    (bus_ack_i),
      .data_i       (data_i),
      .bus_req_o    (bus_req_o),
      .cs_n_o       (cs_n_o),
      .addr_o       (addr_o),
      .addr_oe_o    (addr_oe_o),
      .data_o       (data_o),
      .data_oe_o    (data_oe_o),
      .ale_o        (ale_o),
      .rd_n_o       (rd_n_o),
      .wr_n_o       (wr_n_o),
      .done_o       (done_o),
      .rdata_o      (rdata_o)
   );

   // R12
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_req_o |-> (rd_n_o && wr_n_o && !ale_o && !addr_oe_o && (&cs_n_o)));

endmodule

// File: tb/nand_bus_seq_tb_top.sv
module nand_bus_seq_tb_top;

   localparam int AW = 16;
   localparam int DW = 8;
   localparam int NCS = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          start = 0, rw = 0, reg_we = 0, bus_ack = 1;
   logic [0:0]    cs_sel = 0;
   logic [AW-1:0] addr = 0;
   logic [DW-1:0] wdata = 0, data_in = 0;
   logic [1:0]    reg_addr = 0;
   logic [7:0]    reg_wdata = 0;
   logic          bus_req, addr_oe, data_oe, ale, rd_n, wr_n, done;
   logic [NCS-1:0] cs_n;
   logic [AW-1:0] addr_out;
   logic [DW-1:0] data_out, rdata;

   nand_bus_seq dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rw_i(rw), .cs_sel_i(cs_sel),
      .addr_i(addr), .wdata_i(wdata), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
      .reg_wdata_i(reg_wdata), .bus_ack_i(bus_ack), .data_i(data_in),
      .bus_req_o(bus_req), .cs_n_o(cs_n), .addr_o(addr_out), .addr_oe_o(addr_oe),
      .data_o(data_out), .data_oe_o(data_oe), .ale_o(ale), .rd_n_o(rd_n),
      .wr_n_o(wr_n), .done_o(done), .rdata_o(rdata)
   );

   int checks = 0;
   int errors = 0;

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Behavioural reference: phase 0 idle, 1 bus-get, 2 setup, 3 strobe, 4 hold, 5 final hold
   // kind 0 read, 1 write, 2 latch
   int m_ph = 0, m_cnt = 0, m_kind = 0, m_addr = 0, m_pay = 0, m_cs = 0, m_n = 1, m_m = 1;
   int r_n = 6, r_m = 2, r_lat = 0;
   bit r_pend = 0;
   int m_dbus = 0, m_rdata = 0;
   bit m_extra = 0, m_done = 0;

   always @(posedge clk) begin : model
      bit take;
      if (!rst_n) begin
         m_ph <= 0; m_cnt <= 0; m_kind <= 0; m_addr <= 0; m_pay <= 0; m_cs <= 0;
         m_n <= 1; m_m <= 1; r_n <= 6; r_m <= 2; r_lat <= 0; r_pend <= 0;
         m_dbus <= 0; m_rdata <= 0; m_extra <= 0; m_done <= 0;
      end else begin
         take = (m_ph == 0 || m_ph == 5) && (r_pend || start);
         m_done  <= (m_ph == 5);
         m_extra <= (m_ph == 5) && (m_kind != 0);
         if (m_ph == 3 && m_cnt == m_n && m_kind == 0) m_rdata <= data_in;
         if (m_ph == 1 && bus_ack) m_dbus <= m_pay;
         case (m_ph)
            0: if (take) m_ph <= 1;
            1: if (bus_ack) m_ph <= 2;
            2: begin m_ph <= 3; m_cnt <= 1; end
            3: if (m_cnt == m_n) begin m_ph <= 4; m_cnt <= 1; end else m_cnt <= m_cnt + 1;
            4: if (m_cnt == m_m) begin m_ph <= 5; m_cnt <= 0; end else m_cnt <= m_cnt + 1;
            default: m_ph <= take ? 1 : 0;
         endcase
         if (take) begin
            m_n <= (r_n == 0) ? 1 : r_n;
            m_m <= (r_m == 0) ? 1 : r_m;
            if (r_pend) begin
               m_kind <= 2; m_addr <= 0; m_pay <= r_lat; m_cs <= 0;
               r_pend <= 0;
            end else begin
               m_kind <= rw ? 0 : 1; m_addr <= addr; m_pay <= wdata; m_cs <= cs_sel;
            end
         end
         if (reg_we) begin
            case (reg_addr)
               2'd0: begin r_n <= reg_wdata[3:0]; r_m <= reg_wdata[7:4]; end
               2'd1: begin r_n <= 6; r_m <= 2; r_lat <= 0; r_pend <= 0; end
               2'd2: r_pend <= 1;
               default: r_lat <= reg_wdata[3:0];
            endcase
         end
      end
   end

   // per-clock comparison and strobe run-length monitors
   int wr_run = 0, wr_last = 0, rd_run = 0, rd_last = 0, ale_run = 0, ale_last = 0, ale_count = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         bit on;
         on = (m_ph >= 2);
         check("R1", "bus_req", bus_req, m_ph >= 1);
         check("R5", "addr_oe", addr_oe, on);
         if (on) check("R5", "addr", addr_out, m_addr);
         check("R5", "cs_n", cs_n, (on && m_kind != 2) ? (~(1 << m_cs) & 3) : 3);
         check("R6", "data_oe", data_oe, (on && m_kind != 0) || m_extra);
         if (data_oe) check("R11", "data", data_out, m_dbus);
         check("R3", "wr_n", wr_n, !(m_ph == 3 && m_kind == 1));
         check("R4", "rd_n", rd_n, !(m_kind == 0 && (m_ph == 3 || (m_ph == 4 && m_cnt == 1))));
         check("R11", "ale", ale, m_kind == 2 && (m_ph == 3 || m_ph == 4));
         check("R7", "done", done, m_done);
         check("R4", "rdata", rdata, m_rdata);
      end
      if (!wr_n) wr_run++; else if (wr_run > 0) begin wr_last = wr_run; wr_run = 0; end
      if (!rd_n) rd_run++; else if (rd_run > 0) begin rd_last = rd_run; rd_run = 0; end
      if (ale) ale_run++; else if (ale_run > 0) begin ale_last = ale_run; ale_run = 0; ale_count++; end
   end

   initial forever begin
      @(negedge clk);
      data_in = data_in + 8'd7;
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 0;
   endtask

   task automatic launch(input logic r, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic c);
      @(negedge clk); start = 1; rw = r; addr = a; wdata = d; cs_sel = c;
      @(negedge clk); start = 0;
   endtask

   task automatic wait_done();
      int guard = 0;
      while (!done && guard < 500) begin @(negedge clk); guard++; end
      check("R7", "done seen", done, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      check("R12", "bus_req reset", bus_req, 0);
      check("R12", "strobes reset", {rd_n, wr_n, ale}, 3'b110);
      check("R12", "cs_n reset", cs_n, 3);
      check("R12", "oe reset", {addr_oe, data_oe, done}, 0);
      check("R12", "rdata reset", rdata, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // default timing write then read
      launch(0, 16'h1234, 8'hA5, 1);
      wait_done();
      check("R1", "bus released after done", bus_req, 0);
      check("R3", "write pulse length", wr_last, 6);
      launch(1, 16'h0042, 8'h00, 0);
      wait_done();
      check("R4", "read strobe length", rd_last, 7);

      // R2 zero fields act as one
      reg_write(0, 8'h00);
      launch(0, 16'h0001, 8'h11, 0);
      wait_done();
      check("R2", "pw zero acts as one", wr_last, 1);
      reg_write(0, 8'hFF);
      launch(1, 16'h0002, 8'h00, 1);
      wait_done();
      check("R2", "read length at fifteen", rd_last, 16);

      // R1 bus-get waits for grant
      reg_write(0, 8'h13);
      bus_ack = 0;
      launch(0, 16'h0BAD, 8'h3C, 0);
      repeat (4) @(negedge clk);
      check("R1", "holding in bus-get", {bus_req, addr_oe}, 2'b10);
      bus_ack = 1;
      // R9 timing change mid transfer
      reg_write(0, 8'h25);
      // R8 start while busy is ignored
      launch(1, 16'h0777, 8'h00, 1);
      wait_done();
      check("R9", "old pulse width kept", wr_last, 3);
      repeat (8) @(negedge clk);
      check("R8", "busy start ignored", bus_req, 0);
      launch(0, 16'h0003, 8'h44, 0);
      wait_done();
      check("R9", "new pulse width used", wr_last, 5);

      // R8 chaining with start held
      @(negedge clk); start = 1; rw = 0; addr = 16'h00C0; wdata = 8'h5A; cs_sel = 1;
      @(negedge clk);
      wait_done();
      check("R8", "chained into bus-get", bus_req, 1);
      // R11 pending latch wins over held start
      reg_write(3, 8'h0A);
      reg_write(2, 8'h00);
      @(negedge clk);
      wait_done();
      @(negedge clk);
      wait_done();
      check("R11", "latch transfer ran", ale_count, 1);
      check("R11", "latch strobe length", ale_last, 5 + 2);
      start = 0;
      repeat (20) @(negedge clk);

      // R10 soft reset cancels pending latch and restores defaults
      launch(0, 16'h0050, 8'h99, 0);
      reg_write(2, 8'h00);
      reg_write(1, 8'h00);
      wait_done();
      repeat (10) @(negedge clk);
      check("R10", "pending latch cancelled", ale_count, 1);
      launch(0, 16'h0051, 8'h98, 1);
      wait_done();
      check("R10", "default pulse width", wr_last, 6);
      reg_write(2, 8'h00);
      wait_done();
      check("R10", "latch state cleared", m_dbus, 0);
      check("R11", "second latch transfer", ale_last, 6 + 2);
      repeat (5) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule